// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

The block holds a parameterised number of independent down-counters, each with a control register, a reload register and a live count register, all reached over a simple word-wide register bus. The bus has an address, a write strobe, write data and read data. A write takes effect on the clock edge where the strobe is sampled high. Reads are combinational from the register state. A shared tick-enable input stands in for the selected clock source, so a counter advances only in cycles where that input is high.

When a running counter steps from one to zero, it raises its bit in a shared pending register. A separate shared enable register gates these bits onto a single level interrupt output. Each channel's control bits decide what happens after zero. In single-shot mode the channel stops itself. In auto-reload mode it reloads from its reload register on its next step. Otherwise it keeps running while parked at zero. A per-channel prescaler divides the tick rate by the field value plus one. Software clears pending bits by writing ones to them.

Top module: `tmr_block`

## Requirements
- R1: After reset every mapped register reads zero and `irq` is low.
- R2: Word addresses are as follows. The enable register is at 0x00 and the pending register is at 0x04. For channel n, control is at 0x10+0x10*n, reload at 0x14+0x10*n and count at 0x18+0x10*n. Writes to these addresses read back. Any other address, including one with a nonzero address bit 1 or 0, reads zero and accepts no write.
- R3: The control layout is: bit 0 run, bit 1 auto-reload, bits 3:2 source select (stored only), bits 6:4 prescale, bit 7 single-shot. A running channel lowers its count by one per prescaled step. The count holds whenever the channel is stopped or `tick_en` is low.
- R4: With prescale field p, a step occurs on every (p+1)-th enabled tick, counted from the last control write. A count loaded with N therefore reaches zero N*(p+1) ticks after the run bit is written.
- R5: The step from one to zero sets pending bit n on the same edge. A set takes priority over a clear written in the same cycle.
- R6: In single-shot mode (bit 7 = 1), the run bit clears on the edge that reaches zero, and the count then stays at zero.
- R7: With auto-reload set and single-shot clear, a step taken at zero loads the reload value. The count sequence is then I, I-1, ..., 0, I, ... with a period of I+1 steps.
- R8: With both auto-reload and single-shot clear, the channel stays at zero with the run bit still set, and it raises no further pending bit.
- R9: A write to the count register loads that value on its edge and overrides a step in the same cycle.
- R10: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R11: `irq` is high exactly when some pending bit and its matching enable bit are both set.
- R12: Writes and counting on one channel leave the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick from the selected source |
| addr | input | AW (8) | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The properties assume that a write lasts exactly one strobed cycle. They exclude any cycle with a same-cycle write to the count or control register of the channel they watch, so a software override is never taken for a counting fault. The bench keeps within this by driving one write per strobe on falling edges. It measures expiry latency only after the last control write. It holds `tick_en` steady except during one window where the tick is deliberately frozen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned PRESC_W = 3;

    typedef struct packed {
        logic               oneshot;
        logic [PRESC_W-1:0] presc;
        logic [1:0]         src;
        logic               autold;
        logic               run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SUB_CTRL = 2'd0,
        SUB_INTV = 2'd1,
        SUB_CURV = 2'd2,
        SUB_NONE = 2'd3
    } sub_e;

    function automatic sub_e sub_of(input logic [1:0] word_sel);
        return sub_e'(word_sel);
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          ctrl_we,
    input  logic          intv_we,
    input  logic          cur_we,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] intv_q,
    output logic [DW-1:0] cur_q,
    output logic          expire
);

    logic [PRESC_W-1:0] pcnt_q;
    logic               step, at_zero, reload, dec;

    assign step    = ctrl_q.run && tick_en && (pcnt_q == ctrl_q.presc);
    assign at_zero = (cur_q == '0);
    assign reload  = step && at_zero && ctrl_q.autold && !ctrl_q.oneshot;
    assign dec     = step && !at_zero;
    assign expire  = dec && (cur_q == DW'(1)) && !cur_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            cur_q  <= '0;
            intv_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (ctrl_we)
                pcnt_q <= '0;
            else if (ctrl_q.run && tick_en)
                pcnt_q <= (pcnt_q == ctrl_q.presc) ? '0 : pcnt_q + 1'b1;

            if (cur_we)
                cur_q <= wdata;
            else if (reload)
                cur_q <= intv_q;
            else if (dec)
                cur_q <= cur_q - DW'(1);

            if (intv_we)
                intv_q <= wdata;

            if (ctrl_we)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            else if (expire && ctrl_q.oneshot)
                ctrl_q.run <= 1'b0;
        end
    end

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run || !tick_en) && !cur_we |=> $stable(cur_q));

    p_step_by_one_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run && tick_en && !cur_we && (cur_q != '0)
        |=> (cur_q == $past(cur_q)) || (cur_q == $past(cur_q) - DW'(1)));

    p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (rst)
        expire && ctrl_q.oneshot && !ctrl_we |=> !ctrl_q.run);

    p_reload_value_r7: assert property (@(posedge clk) disable iff (rst)
        reload && !cur_we |=> cur_q == $past(intv_q));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_we,
    input  logic           sts_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] pend_q,
    output logic           irq
);

    logic [NCH-1:0] clr;

    assign clr = sts_we ? wbits : '0;
    assign irq = |(pend_q & en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (en_we)
                en_q <= wbits;
            pend_q <= (pend_q & ~clr) | expire;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> pend_q[i]);
        p_pend_keep_r10: assert property (@(posedge clk) disable iff (rst)
            pend_q[i] && !(sts_we && wbits[i]) |=> pend_q[i]);
    end

endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int unsigned NCH = 2,
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    localparam int unsigned GW = AW - 4;

    logic [GW-1:0]  grp;
    sub_e           sub;
    logic           aligned;
    logic [NCH-1:0] expire, en_q, pend_q;
    ctrl_t          ctrl_a [NCH];
    logic [DW-1:0]  intv_a [NCH];
    logic [DW-1:0]  cur_a  [NCH];

    assign grp     = addr[AW-1:4];
    assign sub     = sub_of(addr[3:2]);
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = wr_en && aligned && (grp == GW'(ch + 1));
        tmr_channel #(.DW(DW)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en),
            .ctrl_we (hit && sub == SUB_CTRL),
            .intv_we (hit && sub == SUB_INTV),
            .cur_we  (hit && sub == SUB_CURV),
            .wdata   (wdata),
            .ctrl_q  (ctrl_a[ch]),
            .intv_q  (intv_a[ch]),
            .cur_q   (cur_a[ch]),
            .expire  (expire[ch])
        );
    end

    tmr_irq #(.NCH(NCH)) irq_i (
        .clk    (clk),
        .rst    (rst),
        .en_we  (wr_en && aligned && grp == '0 && sub == SUB_CTRL),
        .sts_we (wr_en && aligned && grp == '0 && sub == SUB_INTV),
        .wbits  (wdata[NCH-1:0]),
        .expire (expire),
        .en_q   (en_q),
        .pend_q (pend_q),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (grp == '0) begin
                if (sub == SUB_CTRL) rdata[NCH-1:0] = en_q;
                if (sub == SUB_INTV) rdata[NCH-1:0] = pend_q;
            end
            for (int c = 0; c < NCH; c++) begin
                if (grp == GW'(c + 1)) begin
                    case (sub)
                        SUB_CTRL: rdata[CTRL_W-1:0] = ctrl_a[c];
                        SUB_INTV: rdata = intv_a[c];
                        SUB_CURV: rdata = cur_a[c];
                        default:  rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: tb/tmr_block_tb_top.sv
module tmr_block_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr_block dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, ch0_cur;
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        foreach (v[i]) ;
        for (int a = 0; a < 12; a++) begin
            bus_rd(8'(a * 4), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq low", {31'b0, irq}, 32'h0);

        // R2 map, R12 independence
        bus_wr(8'h14, 32'hA5A5_0001);
        bus_wr(8'h24, 32'h5A5A_0002);
        bus_wr(8'h20, 32'h0000_000C);
        bus_rd(8'h14, v); chk("R2 ch0 reload", v, 32'hA5A5_0001);
        bus_rd(8'h24, v); chk("R2 ch1 reload", v, 32'h5A5A_0002);
        bus_rd(8'h20, v); chk("R2 ch1 ctrl src", v, 32'h0000_000C);
        bus_rd(8'h18, v); chk("R12 ch0 count untouched", v, 32'h0);
        bus_rd(8'h10, v); chk("R12 ch0 ctrl untouched", v, 32'h0);
        bus_rd(8'h08, v); chk("R2 unmapped 0x08", v, 32'h0);
        bus_rd(8'h30, v); chk("R2 unmapped 0x30", v, 32'h0);
        bus_wr(8'h15, 32'hFFFF_FFFF);
        bus_rd(8'h14, v); chk("R2 misaligned write ignored", v, 32'hA5A5_0001);
        bus_wr(8'h20, 32'h0);

        // R4 R5 R6 sweep: single-shot latency over count and prescale
        for (int n = 1; n <= 4; n++) begin
            for (int f = 0; f < 8; f++) begin
                bus_wr(8'h10, 32'h0);
                bus_wr(8'h04, 32'h3);
                bus_wr(8'h18, 32'(n));
                bus_wr(8'h10, 32'h81 | 32'(f << 4));
                k = 0;
                v = 0;
                while (k < 100 && v[0] == 1'b0) begin
                    @(negedge clk);
                    k++;
                    bus_rd(8'h04, v);
                end
                chk($sformatf("R4 R5 latency n=%0d p=%0d", n, f), 32'(k), 32'(n * (f + 1)));
                bus_rd(8'h10, v);
                chk("R6 run cleared", v, 32'h80 | 32'(f << 4));
                wait_cyc(3);
                bus_rd(8'h18, v);
                chk("R6 count stays zero", v, 32'h0);
            end
        end

        // R3 freeze, R8 continuous without reload
        bus_wr(8'h04, 32'h3);
        bus_wr(8'h18, 32'd10);
        bus_wr(8'h10, 32'h01);
        tick_en = 1'b0;
        wait_cyc(6);
        bus_rd(8'h18, v); chk("R3 tick low holds", v, 32'd10);
        tick_en = 1'b1;
        wait_cyc(3);
        bus_rd(8'h18, v); chk("R3 three steps", v, 32'd7);
        wait_cyc(7);
        bus_rd(8'h04, v); chk("R5 pending at zero", v, 32'h1);
        bus_wr(8'h04, 32'h1);
        wait_cyc(5);
        bus_rd(8'h04, v); chk("R8 no repeat pending", v, 32'h0);
        bus_rd(8'h18, v); chk("R8 parked at zero", v, 32'h0);
        bus_rd(8'h10, v); chk("R8 still running", v, 32'h01);

        // R7 auto-reload sequence sweep
        for (int iv = 1; iv <= 3; iv++) begin
            bus_wr(8'h10, 32'h0);
            bus_wr(8'h14, 32'(iv));
            bus_wr(8'h18, 32'h0);
            bus_wr(8'h10, 32'h03);
            for (int s = 1; s <= 2 * (iv + 1) + 1; s++) begin
                @(negedge clk);
                bus_rd(8'h18, v);
                chk($sformatf("R7 reload seq I=%0d s=%0d", iv, s), v,
                    32'(iv - ((s - 1) % (iv + 1))));
            end
        end

        // R9 direct count write while running
        bus_wr(8'h18, 32'd100);
        bus_rd(8'h18, v); chk("R9 count load", v, 32'd100);
        @(negedge clk);
        bus_rd(8'h18, v); chk("R9 continues from load", v, 32'd99);

        // R10 write-one-to-clear
        bus_wr(8'h10, 32'h0);
        bus_rd(8'h04, v); chk("R10 pending present", v, 32'h1);
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h04, v); chk("R10 zero write keeps", v, 32'h1);
        bus_wr(8'h04, 32'h1);
        bus_rd(8'h04, v); chk("R10 one write clears", v, 32'h0);

        // R11 gating, R12 independence
        bus_rd(8'h18, ch0_cur);
        bus_wr(8'h28, 32'd1);
        bus_wr(8'h20, 32'h81);
        wait_cyc(2);
        bus_rd(8'h04, v); chk("R5 ch1 pending", v, 32'h2);
        chk("R11 irq off without enable", {31'b0, irq}, 32'h0);
        bus_wr(8'h00, 32'h2);
        chk("R11 irq on", {31'b0, irq}, 32'h1);
        bus_wr(8'h00, 32'h1);
        chk("R11 irq off wrong enable", {31'b0, irq}, 32'h0);
        bus_wr(8'h00, 32'h3);
        bus_wr(8'h04, 32'h2);
        chk("R11 irq off after clear", {31'b0, irq}, 32'h0);
        bus_rd(8'h18, v); chk("R12 ch0 count unchanged", v, ch0_cur);
        bus_rd(8'h00, v); chk("R2 enable readback", v, 32'h3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule